// File: doc/BRIEF.md
# ADC serial interface controller

This block is the digital half of a delta-sigma converter's four-wire serial port. It sequences the converter through three states (converting, asleep, shifting data out) and stands in for the real conversion with a cycle counter. A host watches the busy/idle flag by pulling the active-low chip select low. Once the converter is asleep, the host clocks out the status bit and then the held result word, most significant bit first. Raising chip select part-way through a readout abandons it and starts the next conversion at once.

Every external input passes through a two-flop synchronizer. Edges of chip select and of the serial clock are found in the system clock domain. The serial data line is shown as a data bit plus an output enable; the pad floats the line whenever the enable is low. The result arrives as a plain parallel word from a stub converter and is captured in the cycle the conversion counter expires, so that input has no handshake and no back-pressure. The host paces the serial readout entirely through its clock and never has to wait for the block. The start strobe and the mode flag are plain control pins.

Top module: `adc_serial_ctrl`

## Requirements
- R1: While the chip select input is HIGH, `sdo_oe_o` is 0, three system clocks after the pin changes. While it is LOW, `sdo_oe_o` is 1 after the same latency. This also holds during reset.
- R2: With chip select LOW and no readout under way, `sdo_o` shows the end-of-conversion flag: 1 while a conversion runs and 0 while asleep.
- R3: A conversion lasts CONV_CYCLES system clocks, counted from the cycle in which `start_conv_o` is high. At its end the block goes to sleep on its own, whatever the chip select level.
- R4: The result word is sampled from `result_i` when a conversion ends. It is held unchanged through sleep, even if `result_i` changes, until it is shifted out.
- R5: At each chip-select falling edge, the level of SCK is latched as the clock mode. SCK LOW selects external-clock mode (`ext_mode_o`=1) and SCK HIGH selects the other mode (`ext_mode_o`=0). A readout can start only in external-clock mode. After reset the mode is external.
- R6: A readout begins at the first rising SCK edge seen while asleep, with chip select LOW and external mode latched. That edge samples the end-of-conversion bit, 0. Each following SCK falling edge presents the next result bit, MSB first, so that SCK rising edges 2 to RES_W+1 sample bits RES_W-1 down to 0.
- R7: On the rising SCK edge that samples result bit 0, a new conversion starts. `start_conv_o` pulses and `sdo_o` reads 1 while chip select stays LOW.
- R8: A chip-select LOW-to-HIGH transition during a readout abandons it and starts a new conversion (one `start_conv_o` pulse). The next result read out is that new conversion's word.
- R9: `start_conv_o` is a single-cycle pulse. It is issued once right after reset, and once for each conversion started after that.
- R10: SCK edges while chip select is HIGH change nothing. A readout started after such edges still begins with the end-of-conversion bit and the result MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select from the host (asynchronous) |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| result_i | input | RES_W | Result word from the stub converter |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output enable; line floats when 0 |
| start_conv_o | output | 1 | One-cycle strobe at the start of each conversion |
| ext_mode_o | output | 1 | Latched clock mode, 1 = external serial clock |

## Verification
The bench keeps RES_W at its default of 20. It lowers CONV_CYCLES to 40, so that one run can hold several complete conversions, full readouts, an abandoned readout and a pass in the other clock mode. With 40 cycles, the busy-to-asleep switch can be sampled a few clocks on either side of its expected cycle. The serial clock runs at sixteen system clocks per period, which leaves the synchronizer and output registers room to settle before each host sampling edge.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } sif_state_e;
endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end
    assign q_o[g] = stab_q;
  end
endmodule

// File: rtl/adc_sif_timer.sv
module adc_sif_timer #(
  parameter int CONV_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (launch_i) begin
      cnt_q  <= CNT_W'(CONV_CYCLES - 1);
      busy_q <= 1'b1;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_sif_shifter.sv
module adc_sif_shifter #(
  parameter int RES_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [RES_W-1:0] load_data_i,
  input  logic             shift_i,
  output logic             bit_o,
  output logic [RES_W-1:0] hold_o
);
  logic [RES_W-1:0] sh_q;
  logic             bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= load_data_i;
      bit_q <= 1'b0;
    end else if (shift_i) begin
      bit_q <= sh_q[RES_W-1];
      sh_q  <= {sh_q[RES_W-2:0], 1'b0};
    end
  end

  assign bit_o  = bit_q;
  assign hold_o = sh_q;
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_sif_pkg::*;
#(
  parameter int RES_W       = 20,
  parameter int CONV_CYCLES = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_i,
  input  logic             sck_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             start_conv_o,
  output logic             ext_mode_o
);
  localparam int RC_W = $clog2(RES_W + 1);

  logic [1:0] syncd;
  logic       cs_s, sck_s, cs_d, sck_d;
  logic       cs_fall, cs_rise, sck_rise, sck_fall;

  adc_sif_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_n_i, sck_i}),
    .q_o   (syncd)
  );
  assign cs_s  = syncd[1];
  assign sck_s = syncd[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_fall  =  cs_d  & ~cs_s;
  assign cs_rise  = ~cs_d  &  cs_s;
  assign sck_rise = ~sck_d &  sck_s;
  assign sck_fall =  sck_d & ~sck_s;

  sif_state_e      state_q, state_d;
  logic [RC_W-1:0] rise_q, rise_d;
  logic            init_q, ext_mode_q, launch;
  logic            conv_busy, conv_done;
  logic            out_bit, shift_en;
  logic [RES_W-1:0] hold_word;
  logic            sdo_q, oe_q, start_q;

  adc_sif_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .busy_o   (conv_busy),
    .done_o   (conv_done)
  );

  assign shift_en = (state_q == ST_DOUT) && sck_fall;

  adc_sif_shifter #(.RES_W(RES_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (conv_done),
    .load_data_i (result_i),
    .shift_i     (shift_en),
    .bit_o       (out_bit),
    .hold_o      (hold_word)
  );

  always_comb begin
    state_d = state_q;
    rise_d  = rise_q;
    launch  = init_q;
    unique case (state_q)
      ST_CONV: begin
        if (conv_done) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!cs_s && sck_rise && ext_mode_q) begin
          state_d = ST_DOUT;
          rise_d  = '0;
        end
      end
      ST_DOUT: begin
        if (cs_rise) begin
          launch  = 1'b1;
          state_d = ST_CONV;
        end else if (sck_rise) begin
          if (rise_q == RC_W'(RES_W - 1)) begin
            launch  = 1'b1;
            state_d = ST_CONV;
          end else begin
            rise_d = rise_q + 1'b1;
          end
        end
      end
      default: state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_CONV;
      rise_q     <= '0;
      init_q     <= 1'b1;
      ext_mode_q <= 1'b1;
      sdo_q      <= 1'b1;
      oe_q       <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rise_q  <= rise_d;
      init_q  <= 1'b0;
      start_q <= launch;
      oe_q    <= ~cs_s;
      if (cs_fall) ext_mode_q <= ~sck_s;
      unique case (state_q)
        ST_SLEEP: sdo_q <= 1'b0;
        ST_DOUT:  sdo_q <= out_bit;
        default:  sdo_q <= 1'b1;
      endcase
    end
  end

  assign sdo_o        = sdo_q;
  assign sdo_oe_o     = oe_q;
  assign start_conv_o = start_q;
  assign ext_mode_o   = ext_mode_q;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk
  import adc_sif_pkg::*;
#(
  parameter int RES_W = 20,
  parameter int RC_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_i,
  input logic             sdo_oe_o,
  input logic             start_conv_o,
  input logic             ext_mode_o,
  input logic             conv_done,
  input logic             conv_busy,
  input sif_state_e       state_q,
  input logic [RC_W-1:0]  rise_q,
  input logic [RES_W-1:0] hold_word
);
  AST_OE_FOLLOWS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_o == !$past(cs_n_i, 3)); // R1

  AST_SLEEP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (state_q == ST_SLEEP)); // R3

  AST_HOLD_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && $past(state_q) == ST_SLEEP) |-> $stable(hold_word)); // R4

  AST_DOUT_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOUT) |-> ext_mode_o); // R5

  AST_RISE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOUT) |-> (rise_q < RC_W'(RES_W))); // R6

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv_o |=> !start_conv_o); // R9

  AST_START_ARMS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv_o |-> (conv_busy && state_q == ST_CONV)); // R9
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.RES_W(RES_W), .RC_W(RC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n_i       (cs_n_i),
  .sdo_oe_o     (sdo_oe_o),
  .start_conv_o (start_conv_o),
  .ext_mode_o   (ext_mode_o),
  .conv_done    (conv_done),
  .conv_busy    (conv_busy),
  .state_q      (state_q),
  .rise_q       (rise_q),
  .hold_word    (hold_word)
);

// File: tb/adc_serial_ctrl_bench.sv
module adc_serial_ctrl_bench;
  localparam int RES_W = 20;
  localparam int CONV  = 40;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic [RES_W-1:0] result = '0;
  logic sdo, sdo_oe, start_conv, ext_mode;

  int n_checks = 0;
  int n_fail = 0;
  int starts = 0;
  bit done = 0;
  bit mon_en = 0;
  string cur_req = "R6";
  logic exp_q[$];

  always #10 clk = ~clk;

  adc_serial_ctrl #(.RES_W(RES_W), .CONV_CYCLES(CONV)) u_adc_serial_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n),
    .sck_i        (sck),
    .result_i     (result),
    .sdo_o        (sdo),
    .sdo_oe_o     (sdo_oe),
    .start_conv_o (start_conv),
    .ext_mode_o   (ext_mode)
  );

  always @(negedge clk) if (rst_n && start_conv) starts++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: host sampling edge pops the next expected bit.
  always @(posedge sck) begin
    if (mon_en) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: actual=%0b expected=none (queue empty)", cur_req, sdo);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (sdo !== e || sdo_oe !== 1'b1) begin
          n_fail++;
          $display("FAIL %s: actual=%0b/oe%0b expected=%0b", cur_req, sdo, sdo_oe, e);
        end
      end
    end
  end

  // Driver: pushes the expected stream, then clocks nrise rising edges.
  task automatic readout(string req, int nrise, logic [RES_W-1:0] word);
    cur_req = req;
    exp_q.push_back(1'b0);
    for (int i = 1; i < nrise; i++) exp_q.push_back(word[RES_W-i]);
    mon_en = 1;
    for (int i = 0; i < nrise; i++) begin
      @(negedge clk) sck = 1'b1;
      clocks(HALF);
      sck = 1'b0;
      clocks(HALF);
    end
    mon_en = 0;
    check({req, " queue drained"}, exp_q.size(), 0);
  endtask

  task automatic wait_start();
    int s0;
    s0 = starts;
    while (starts == s0) @(negedge clk);
  endtask

  initial begin
    int s;
    clocks(3);
    check("R1 reset oe", sdo_oe, 0);
    @(negedge clk) rst_n = 1'b1;
    clocks(2);
    check("R9 start after reset", starts, 1);
    check("R5 reset mode", ext_mode, 1);

    // R3/R2/R5: chip select low through a conversion, SCK low at the fall.
    cs_n = 1'b0;
    result = 20'hA5C3E;
    clocks(CONV - 12);
    check("R1 oe with cs low", sdo_oe, 1);
    check("R2 busy flag", sdo, 1);
    check("R5 ext mode latched", ext_mode, 1);
    clocks(20);
    check("R3 asleep after conversion", sdo, 0);
    result = 20'h12345;
    clocks(5);
    check("R2 sleep flag", sdo, 0);
    check("R9 single start so far", starts, 1);

    // R4/R6/R7: full readout of the held word.
    s = starts;
    readout("R4", RES_W + 1, 20'hA5C3E);
    check("R7 start after last bit", starts, s + 1);
    check("R7 busy after readout", sdo, 1);
    @(negedge clk) cs_n = 1'b1;
    clocks(4);
    check("R1 oe after cs high", sdo_oe, 0);

    // R5: other clock mode, SCK high at the fall; readout must not start.
    result = 20'h5A1B7;
    clocks(CONV + 10);
    sck = 1'b1;
    clocks(4);
    cs_n = 1'b0;
    clocks(6);
    check("R5 other mode latched", ext_mode, 0);
    s = starts;
    for (int i = 0; i < 4; i++) begin
      sck = 1'b0;
      clocks(HALF);
      sck = 1'b1;
      clocks(HALF);
    end
    check("R5 no readout in other mode", sdo, 0);
    check("R5 no start in other mode", starts, s);
    sck = 1'b0;
    clocks(4);
    cs_n = 1'b1;
    clocks(6);

    // R8: abandon a readout after EOC plus four bits.
    cs_n = 1'b0;
    clocks(6);
    check("R5 ext mode relatched", ext_mode, 1);
    readout("R8", 5, 20'h5A1B7);
    s = starts;
    result = 20'h80001;
    cs_n = 1'b1;
    clocks(6);
    check("R8 abort starts conversion", starts, s + 1);
    cs_n = 1'b0;
    clocks(6);
    check("R8 busy after abort", sdo, 1);

    // R10: SCK edges while chip select is high do nothing in sleep.
    cs_n = 1'b1;
    clocks(CONV + 10);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1;
      clocks(HALF);
      sck = 1'b0;
      clocks(HALF);
    end
    result = 20'h0FFFF;
    cs_n = 1'b0;
    clocks(6);
    check("R10 still asleep", sdo, 0);
    check("R10 no start from idle SCK", starts, s + 1);
    readout("R10", RES_W + 1, 20'h80001);
    @(negedge clk) cs_n = 1'b1;
    clocks(6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end
endmodule